// File: doc/BRIEF.md
# Single-Level Paging Address Translator

This block maps a 16-bit virtual address onto a 15-bit physical address using a flat table of sixteen entries. The top four address bits select a table entry. The low twelve bits are the byte offset inside a 4096-byte page. A table entry holds a 3-bit frame number and a present flag. When the selected entry is present, the frame number replaces the page number and the offset passes through untouched. When the entry is absent, no address is produced. The response instead signals a page fault, and the faulting page number is captured for the trap handler.

Software fills the table through a single-cycle write port. Translation requests arrive with a valid strobe, and each one gets a response exactly one cycle later. A new request may be presented in every cycle. Reset marks every page absent, so any access made before the table is loaded faults.

Top module: `page_xlate`

## Requirements
- R1: While reset is held, and in the first cycle after it, rsp_valid, rsp_fault, rsp_paddr and fault_vpn are all zero. Reset marks every one of the sixteen pages absent, so a request to any page after reset faults.
- R2: rsp_valid is high in exactly those cycles that follow a cycle with req_valid high. One response is given per request, and back-to-back requests get back-to-back responses.
- R3: For a present page, rsp_paddr equals the stored 3-bit frame number in bits 14:12 above req_vaddr[11:0] in bits 11:0. The page number used is req_vaddr[15:12], and rsp_fault is low.
- R4: For an absent page, the response has rsp_fault high and rsp_paddr equal to zero.
- R5: On a fault response, fault_vpn holds req_vaddr[15:12] of the faulting request. fault_vpn keeps that value until the next fault response.
- R6: A table write (pt_we high, with pt_idx, pt_frame and pt_present) first affects requests presented in the following cycle. A request to the same page in the cycle of the write is translated with the old entry.
- R7: Writing an entry with pt_present low unmaps that page, and later requests to it fault.
- R8: When rsp_valid is low, rsp_fault is low and rsp_paddr is zero.
- R9: With page 5 mapped to frame 3, virtual address 20500 translates to physical address 12308.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| pt_we | input | 1 | Page-table write strobe |
| pt_idx | input | 4 | Page number of the entry being written |
| pt_frame | input | 3 | Frame number to store |
| pt_present | input | 1 | Present flag to store |
| req_valid | input | 1 | Translation request strobe |
| req_vaddr | input | 16 | Virtual address to translate |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_paddr | output | 15 | Translated physical address, zero on a fault |
| rsp_fault | output | 1 | Page fault for the responding request |
| fault_vpn | output | 4 | Page number of the most recent fault |

## Verification
A table write and a translation request can land in the same cycle and name the same page. That makes the ordering between the two functions visible at the ports. The bench provokes this by writing a page and requesting it in one cycle, in both directions: mapping an absent page and unmapping a present one. The old entry must decide the response, and the request in the next cycle must see the new entry. A behavioural reference model applies each write only after computing the expected response for that cycle, and it is compared with the ports on every clock. Long stretches of mixed random writes and requests also make same-page collisions occur naturally.

// File: rtl/page_xlate_pkg.sv
package page_xlate_pkg;

    parameter int unsigned DEF_VA_W  = 16;
    parameter int unsigned DEF_OFF_W = 12;
    parameter int unsigned DEF_PA_W  = 15;

    typedef enum logic [1:0] {
        XL_IDLE   = 2'd0,
        XL_MAPPED = 2'd1,
        XL_FAULT  = 2'd2
    } xl_kind_e;

endpackage

// File: rtl/pt_store.sv
module pt_store #(
    parameter int unsigned VPN_W = 4,
    parameter int unsigned PFN_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [VPN_W-1:0] wr_idx,
    input  logic [PFN_W-1:0] wr_frame,
    input  logic             wr_present,
    input  logic [VPN_W-1:0] rd_idx,
    output logic [PFN_W-1:0] rd_frame,
    output logic             rd_present
);
    localparam int unsigned N_ENT = 1 << VPN_W;

    typedef struct packed {
        logic [PFN_W-1:0] frame;
        logic             present;
    } ent_t;

    ent_t tab_d [N_ENT];
    ent_t tab_q [N_ENT];

    always_comb begin
        for (int i = 0; i < N_ENT; i++) begin
            tab_d[i] = tab_q[i];
            if (wr_en && (wr_idx == VPN_W'(i))) begin
                tab_d[i].frame   = wr_frame;
                tab_d[i].present = wr_present;
            end
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < N_ENT; i++) begin
            if (!rst_n) begin
                tab_q[i] <= '0;
            end else begin
                tab_q[i] <= tab_d[i];
            end
        end
    end

    assign rd_frame   = tab_q[rd_idx].frame;
    assign rd_present = tab_q[rd_idx].present;

endmodule

// File: rtl/xlate_core.sv
module xlate_core
    import page_xlate_pkg::*;
#(
    parameter int unsigned VPN_W = 4,
    parameter int unsigned PFN_W = 3,
    parameter int unsigned OFF_W = 12
) (
    input  logic                   req_valid,
    input  logic [VPN_W+OFF_W-1:0] req_vaddr,
    input  logic [PFN_W-1:0]       ent_frame,
    input  logic                   ent_present,
    output logic [VPN_W-1:0]       vpn,
    output xl_kind_e               kind,
    output logic [PFN_W+OFF_W-1:0] paddr
);
    logic [OFF_W-1:0] offset;

    always_comb begin
        vpn    = req_vaddr[VPN_W+OFF_W-1:OFF_W];
        offset = req_vaddr[OFF_W-1:0];
        kind   = XL_IDLE;
        paddr  = '0;
        if (req_valid) begin
            if (ent_present) begin
                kind  = XL_MAPPED;
                paddr = {ent_frame, offset};
            end else begin
                kind  = XL_FAULT;
            end
        end
    end

endmodule

// File: rtl/page_xlate.sv
module page_xlate
    import page_xlate_pkg::*;
#(
    parameter int unsigned VA_W  = DEF_VA_W,
    parameter int unsigned OFF_W = DEF_OFF_W,
    parameter int unsigned PA_W  = DEF_PA_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  pt_we,
    input  logic [VA_W-OFF_W-1:0] pt_idx,
    input  logic [PA_W-OFF_W-1:0] pt_frame,
    input  logic                  pt_present,
    input  logic                  req_valid,
    input  logic [VA_W-1:0]       req_vaddr,
    output logic                  rsp_valid,
    output logic [PA_W-1:0]       rsp_paddr,
    output logic                  rsp_fault,
    output logic [VA_W-OFF_W-1:0] fault_vpn
);
    localparam int unsigned VPN_W = VA_W - OFF_W;
    localparam int unsigned PFN_W = PA_W - OFF_W;

    typedef struct packed {
        logic             valid;
        logic             fault;
        logic [PA_W-1:0]  paddr;
        logic [VPN_W-1:0] fvpn;
    } rsp_t;

    rsp_t st_d, st_q;

    logic [VPN_W-1:0] vpn;
    logic [PFN_W-1:0] ent_frame;
    logic             ent_present;
    xl_kind_e         kind;
    logic [PA_W-1:0]  core_paddr;

    pt_store #(.VPN_W(VPN_W), .PFN_W(PFN_W)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (pt_we),
        .wr_idx     (pt_idx),
        .wr_frame   (pt_frame),
        .wr_present (pt_present),
        .rd_idx     (vpn),
        .rd_frame   (ent_frame),
        .rd_present (ent_present)
    );

    xlate_core #(.VPN_W(VPN_W), .PFN_W(PFN_W), .OFF_W(OFF_W)) u_core (
        .req_valid   (req_valid),
        .req_vaddr   (req_vaddr),
        .ent_frame   (ent_frame),
        .ent_present (ent_present),
        .vpn         (vpn),
        .kind        (kind),
        .paddr       (core_paddr)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = (kind != XL_IDLE);
        st_d.fault = (kind == XL_FAULT);
        st_d.paddr = (kind == XL_MAPPED) ? core_paddr : '0;
        if (kind == XL_FAULT) begin
            st_d.fvpn = vpn;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rsp_valid = st_q.valid;
    assign rsp_fault = st_q.fault;
    assign rsp_paddr = st_q.paddr;
    assign fault_vpn = st_q.fvpn;

endmodule

// File: rtl/page_xlate_chk.sv
module page_xlate_chk #(
    parameter int unsigned VA_W  = 16,
    parameter int unsigned OFF_W = 12,
    parameter int unsigned PA_W  = 15
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  req_valid,
    input logic [VA_W-1:0]       req_vaddr,
    input logic                  rsp_valid,
    input logic [PA_W-1:0]       rsp_paddr,
    input logic                  rsp_fault,
    input logic [VA_W-OFF_W-1:0] fault_vpn
);
    p_valid_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid == $past(req_valid && rst_n));

    p_offset_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_fault) |-> rsp_paddr[OFF_W-1:0] == $past(req_vaddr[OFF_W-1:0]));

    p_fault_zero_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> rsp_paddr == '0);

    p_vpn_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> fault_vpn == $past(req_vaddr[VA_W-1:OFF_W]));

    p_vpn_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_fault |-> $stable(fault_vpn));

    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (!rsp_fault && rsp_paddr == '0));

endmodule

bind page_xlate page_xlate_chk #(.VA_W(VA_W), .OFF_W(OFF_W), .PA_W(PA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_vaddr (req_vaddr),
    .rsp_valid (rsp_valid),
    .rsp_paddr (rsp_paddr),
    .rsp_fault (rsp_fault),
    .fault_vpn (fault_vpn)
);

// File: tb/page_xlate_bench.sv
module page_xlate_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pt_we = 1'b0;
    logic [3:0]  pt_idx = '0;
    logic [2:0]  pt_frame = '0;
    logic        pt_present = 1'b0;
    logic        req_valid = 1'b0;
    logic [15:0] req_vaddr = '0;
    logic        rsp_valid;
    logic [14:0] rsp_paddr;
    logic        rsp_fault;
    logic [3:0]  fault_vpn;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    int m_frame [16];
    bit m_pres  [16];
    bit exp_valid = 1'b0;
    bit exp_fault = 1'b0;
    int exp_paddr = 0;
    int exp_vpn   = 0;
    string exp_tag = "R1";
    int lfsr = 32'h1ACE5;

    always #5 clk = ~clk;

    page_xlate u_page_xlate (
        .clk(clk), .rst_n(rst_n), .pt_we(pt_we), .pt_idx(pt_idx),
        .pt_frame(pt_frame), .pt_present(pt_present), .req_valid(req_valid),
        .req_vaddr(req_vaddr), .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
        .rsp_fault(rsp_fault), .fault_vpn(fault_vpn)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic compare_all();
        chk({exp_tag, " R2 rsp_valid"}, int'(rsp_valid), int'(exp_valid));
        chk({exp_tag, " R4 rsp_fault"}, int'(rsp_fault), int'(exp_fault));
        chk({exp_tag, " R3 rsp_paddr"}, int'(rsp_paddr), exp_paddr);
        chk({exp_tag, " R5 fault_vpn"}, int'(fault_vpn), exp_vpn);
    endtask

    // Drive one cycle; the model reads the table before applying the write (R6).
    task automatic step(input string tag, input bit we, input int idx, input int frm,
                        input bit pres, input bit rv, input int va);
        int pg;
        @(negedge clk);
        compare_all();
        pt_we = we; pt_idx = 4'(idx); pt_frame = 3'(frm); pt_present = pres;
        req_valid = rv; req_vaddr = 16'(va);
        exp_tag = tag;
        pg = (va >> 12) & 15;
        exp_valid = rv;
        exp_fault = rv && !m_pres[pg];
        exp_paddr = (rv && m_pres[pg]) ? ((m_frame[pg] << 12) | (va & 12'hFFF)) : 0;
        if (exp_fault) exp_vpn = pg;
        if (we) begin
            m_frame[idx & 15] = frm & 7;
            m_pres[idx & 15]  = pres;
        end
    endtask

    initial begin
        for (int i = 0; i < 16; i++) begin
            m_frame[i] = 0;
            m_pres[i]  = 1'b0;
        end
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            compare_all(); // R1 outputs zero under reset
        end
        rst_n = 1'b1;
        // R1: every page starts absent
        for (int p = 0; p < 16; p++) step("R1", 0, 0, 0, 0, 1, (p << 12) | (p * 7));
        // R9 worked example
        step("R9", 1, 5, 3, 1, 0, 0);
        step("R9", 0, 0, 0, 0, 1, 20500);
        @(negedge clk);
        chk("R9 example paddr", int'(rsp_paddr), 12308);
        compare_all();
        // R6: write and request of the same page in one cycle
        step("R6", 1, 2, 6, 1, 1, 16'h2ABC);
        step("R6", 0, 0, 0, 0, 1, 16'h2ABC);
        step("R6", 1, 2, 6, 0, 1, 16'h2123);
        step("R6", 0, 0, 0, 0, 1, 16'h2123);
        // R2/R3: back-to-back mapped requests
        step("R3", 1, 15, 7, 1, 1, 16'h5FFF);
        step("R3", 1, 0, 1, 1, 1, 16'hF000);
        step("R3", 0, 0, 0, 0, 1, 16'h0FFF);
        step("R2", 0, 0, 0, 0, 1, 16'hFFFF);
        // R8: idle cycles stay quiet
        step("R8", 0, 0, 0, 0, 0, 16'h5555);
        step("R8", 1, 9, 4, 1, 0, 16'h9000);
        // R7: unmap page 5
        step("R7", 1, 5, 3, 0, 0, 0);
        step("R7", 0, 0, 0, 0, 1, 20500);
        step("R5", 0, 0, 0, 0, 1, 16'h9010);
        step("R5", 0, 0, 0, 0, 0, 0);
        // mixed random traffic
        for (int n = 0; n < 400; n++) begin
            lfsr = (lfsr >> 1) ^ ((lfsr & 1) != 0 ? 32'hB4BCD35C : 0);
            step("R3", lfsr[0], lfsr[7:4], lfsr[10:8], lfsr[11], lfsr[12] | lfsr[13],
                 (lfsr[2] ? lfsr[7:4] : lfsr[19:16]) << 12 | lfsr[31:20]);
        end
        step("R2", 0, 0, 0, 0, 0, 0);
        @(negedge clk);
        compare_all();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule